// File: doc/BRIEF.md
# Insertion Shift Sorter with Counter-Matched Readout

This block keeps a list of wide records ordered by a 16-bit key while they are being written in. Each record carries a 16-bit key and a 64-bit payload. The store is a chain of register slots, and each slot has its own comparator against the incoming key. When a record arrives, every slot whose key is larger than the new key, or which is empty, moves its contents one place toward the tail. The first of those slots takes the new record. The list therefore stays sorted at a rate of one record per clock, with no sorting pass afterwards.

In readout mode the chain moves the other way, toward the head. A 16-bit address counter runs once per clock, and only the head key is compared with it. When the head key equals the counter, the next clock edge does three things: it presents the head payload on a 64-bit output, it raises a one-cycle valid strobe, and it removes the head. Records therefore leave in key order at the counter positions that match their keys, with no search across all entries.

A mode input chooses between loading and readout. A synchronous clear empties the store. Status outputs give the fill count, a full level and a one-cycle duplicate-key strobe.

Top module: `keyed_shift_sorter`

## Requirements
- R1: With mode = 0 (load) and in_valid = 1, an accepted record is placed in its ascending-key position. The block accepts a new record on every clock with no stall, so records come out of readout in ascending key order whatever order they were loaded in.
- R2: The valid records always sit in adjacent slots starting at the head, with strictly rising keys from head to tail.
- R3: `count` equals the number of stored records. It rises by one on each accepted insert and falls by one on each readout match.
- R4: A load-mode insert whose key equals a stored key is dropped and leaves the store unchanged. `dup_err` is 1 for exactly the clock after that insert, and 0 after every other clock.
- R5: `full` is 1 exactly when `count` equals DEPTH. An insert of a new key while full is dropped, and `count` stays at DEPTH.
- R6: With mode = 1 (readout), if the head is valid and its key equals the address counter, then after that clock edge `out_valid` = 1 and `out_payload` holds the head payload for one cycle, and the head is removed. After every other clock edge `out_valid` = 0 and `out_payload` = 0.
- R7: The address counter is 0 while mode = 0, so every readout compares with 0 on its first clock. It then adds one on each readout clock and wraps from 65535 to 0. A key K loaded before readout is therefore output on the (K+1)-th readout clock.
- R8: in_valid is ignored while mode = 1, and `count` does not change because of it.
- R9: `clear` = 1 empties every slot at the clock edge. It also zeroes `count`, `out_valid`, `out_payload` and `dup_err`, and it overrides both a simultaneous insert and a simultaneous readout match. It does not change the address counter.
- R10: After reset, `count`, `full`, `out_valid`, `out_payload` and `dup_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous empty of all slots |
| mode | input | 1 | 0 = load, 1 = readout |
| in_valid | input | 1 | Insert request (load mode only) |
| in_key | input | KEY_W (16) | Sort key of the incoming record |
| in_payload | input | PAY_W (64) | Payload of the incoming record |
| out_valid | output | 1 | One-cycle strobe on a readout match |
| out_payload | output | PAY_W (64) | Payload of the matched record, 0 otherwise |
| dup_err | output | 1 | One-cycle strobe after a dropped duplicate insert |
| full | output | 1 | All slots occupied |
| count | output | CNT_W ($clog2(DEPTH+1), 7) | Number of stored records |

## Verification
The ordering and readout properties assume that keys are compared with an address that starts at zero on entry to readout and never passes a stored key without matching it. This holds only because the store stays sorted and readout always restarts from zero. The stimulus therefore never inserts during readout except to show that such an insert is ignored, and it switches back to load mode before adding keys that are smaller than keys already read. The duplicate and full cases use keys whose presence the bench model tracks, so every dropped insert is an intended one. The stimulus also includes key 0 and key 65535 in a full store, which exercise the first and last counter positions.

// File: rtl/kss_pkg.sv
package kss_pkg;

   typedef enum logic {
      PH_LOAD = 1'b0,
      PH_READ = 1'b1
   } phase_e;

   function automatic int unsigned occ_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/kss_slot.sv
module kss_slot #(
   parameter int KEY_W   = 16,
   parameter int PAY_W   = 64,
   parameter bit IS_HEAD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             ins_go,
   input  logic             pop_go,
   input  logic [KEY_W-1:0] new_key,
   input  logic [PAY_W-1:0] new_pay,
   input  logic             prv_gt,
   input  logic             prv_vld,
   input  logic [KEY_W-1:0] prv_key,
   input  logic [PAY_W-1:0] prv_pay,
   input  logic             nxt_vld,
   input  logic [KEY_W-1:0] nxt_key,
   input  logic [PAY_W-1:0] nxt_pay,
   output logic             vld,
   output logic [KEY_W-1:0] key,
   output logic [PAY_W-1:0] pay,
   output logic             gt,
   output logic             eq
);

   logic take_prev;
   logic take_new;

   // slot yields to the newcomer if empty or holding a larger key
   assign gt        = !vld || (key > new_key);
   assign eq        = vld && (key == new_key);
   assign take_prev = gt && prv_gt;
   assign take_new  = gt && !prv_gt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
      end else if (clear) begin
         vld <= 1'b0;
      end else if (ins_go) begin
         if (take_prev)     vld <= prv_vld;
         else if (take_new) vld <= 1'b1;
      end else if (pop_go) begin
         vld <= nxt_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (!clear && ins_go) begin
         if (take_prev) begin
            key <= prv_key;
            pay <= prv_pay;
         end else if (take_new) begin
            key <= new_key;
            pay <= new_pay;
         end
      end else if (!clear && pop_go) begin
         key <= nxt_key;
         pay <= nxt_pay;
      end
   end

   // R2: neighbours hold strictly increasing keys
   a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (prv_vld && vld) |-> (prv_key < key));

   generate
      if (!IS_HEAD) begin : g_body
         // R2: no hole in front of an occupied slot
         a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
            vld |-> prv_vld);
         // R1: yield flags form a thermometer along the chain
         a_r1_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
            prv_gt |-> gt);
      end
   endgenerate

endmodule

// File: rtl/kss_ctrl.sv
module kss_ctrl
   import kss_pkg::*;
#(
   parameter int KEY_W = 16,
   parameter int PAY_W = 64,
   parameter int DEPTH = 100,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             mode,
   input  logic             in_valid,
   input  logic             any_eq,
   input  logic             any_gt,
   input  logic             tail_vld,
   input  logic             head_vld,
   input  logic [KEY_W-1:0] head_key,
   input  logic [PAY_W-1:0] head_pay,
   output logic             ins_go,
   output logic             pop_go,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             dup_err,
   output logic             out_valid,
   output logic [PAY_W-1:0] out_payload
);

   phase_e           phase;
   logic [KEY_W-1:0] addr;
   logic             run_q;
   logic             load_req;

   assign phase    = phase_e'(mode);
   assign load_req = !clear && (phase == PH_LOAD) && in_valid;
   assign ins_go   = load_req && !any_eq && !tail_vld;
   assign pop_go   = !clear && (phase == PH_READ) && head_vld && (head_key == addr);
   assign full     = tail_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         run_q <= 1'b0;
      end else begin
         run_q <= 1'b1;
         if (phase == PH_READ) addr <= addr + 1'b1;
         else                  addr <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count       <= '0;
         dup_err     <= 1'b0;
         out_valid   <= 1'b0;
         out_payload <= '0;
      end else if (clear) begin
         count       <= '0;
         dup_err     <= 1'b0;
         out_valid   <= 1'b0;
         out_payload <= '0;
      end else begin
         dup_err     <= load_req && any_eq;
         out_valid   <= pop_go;
         out_payload <= pop_go ? head_pay : '0;
         if (ins_go)      count <= count + 1'b1;
         else if (pop_go) count <= count - 1'b1;
      end
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r5_full_level: assert property (@(posedge clk) disable iff (!rst_n)
      full == (count == CNT_W'(DEPTH)));

   a_r5_room_open: assert property (@(posedge clk) disable iff (!rst_n)
      !full |-> any_gt);

   a_r4_dup_cause: assert property (@(posedge clk) disable iff (!rst_n)
      dup_err |-> $past(in_valid && (phase == PH_LOAD)));

   a_r6_out_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(phase == PH_READ));

   a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(phase == PH_READ)) |-> (addr == KEY_W'($past(addr) + 1'b1)));

   a_r7_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(phase == PH_LOAD)) |-> (addr == '0));

   a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(clear)) |-> (count == '0 && !out_valid && !dup_err));

endmodule

// File: rtl/keyed_shift_sorter.sv
module keyed_shift_sorter
   import kss_pkg::*;
#(
   parameter int DEPTH = 100,
   parameter int KEY_W = 16,
   parameter int PAY_W = 64,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             mode,
   input  logic             in_valid,
   input  logic [KEY_W-1:0] in_key,
   input  logic [PAY_W-1:0] in_payload,
   output logic             out_valid,
   output logic [PAY_W-1:0] out_payload,
   output logic             dup_err,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("keyed_shift_sorter: DEPTH must be at least 2");
      end
      if (KEY_W < 1 || KEY_W > 32) begin : g_bad_key
         $error("keyed_shift_sorter: KEY_W must be 1..32");
      end
      if (PAY_W < 1) begin : g_bad_pay
         $error("keyed_shift_sorter: PAY_W must be positive");
      end
   endgenerate

   logic [DEPTH-1:0] vld_a;
   logic [DEPTH-1:0] gt_a;
   logic [DEPTH-1:0] eq_a;
   logic [KEY_W-1:0] key_a [DEPTH];
   logic [PAY_W-1:0] pay_a [DEPTH];
   logic             ins_go;
   logic             pop_go;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic             p_gt;
         logic             p_vld;
         logic [KEY_W-1:0] p_key;
         logic [PAY_W-1:0] p_pay;
         logic             n_vld;
         logic [KEY_W-1:0] n_key;
         logic [PAY_W-1:0] n_pay;

         if (i == 0) begin : g_head_side
            assign p_gt  = 1'b0;
            assign p_vld = 1'b0;
            assign p_key = '0;
            assign p_pay = '0;
         end else begin : g_link_prev
            assign p_gt  = gt_a[i-1];
            assign p_vld = vld_a[i-1];
            assign p_key = key_a[i-1];
            assign p_pay = pay_a[i-1];
         end

         if (i == DEPTH - 1) begin : g_tail_side
            assign n_vld = 1'b0;
            assign n_key = '0;
            assign n_pay = '0;
         end else begin : g_link_next
            assign n_vld = vld_a[i+1];
            assign n_key = key_a[i+1];
            assign n_pay = pay_a[i+1];
         end

         kss_slot #(
            .KEY_W  (KEY_W),
            .PAY_W  (PAY_W),
            .IS_HEAD(i == 0)
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear),
            .ins_go (ins_go),
            .pop_go (pop_go),
            .new_key(in_key),
            .new_pay(in_payload),
            .prv_gt (p_gt),
            .prv_vld(p_vld),
            .prv_key(p_key),
            .prv_pay(p_pay),
            .nxt_vld(n_vld),
            .nxt_key(n_key),
            .nxt_pay(n_pay),
            .vld    (vld_a[i]),
            .key    (key_a[i]),
            .pay    (pay_a[i]),
            .gt     (gt_a[i]),
            .eq     (eq_a[i])
         );
      end
   endgenerate

   kss_ctrl #(
      .KEY_W(KEY_W),
      .PAY_W(PAY_W),
      .DEPTH(DEPTH)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .mode       (mode),
      .in_valid   (in_valid),
      .any_eq     (|eq_a),
      .any_gt     (|gt_a),
      .tail_vld   (vld_a[DEPTH-1]),
      .head_vld   (vld_a[0]),
      .head_key   (key_a[0]),
      .head_pay   (pay_a[0]),
      .ins_go     (ins_go),
      .pop_go     (pop_go),
      .count      (count),
      .full       (full),
      .dup_err    (dup_err),
      .out_valid  (out_valid),
      .out_payload(out_payload)
   );

   // R3: the running count agrees with the occupied slots
   a_r3_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
      count == CNT_W'($countones(vld_a)));

endmodule

// File: tb/keyed_shift_sorter_bench.sv
module keyed_shift_sorter_bench;

   localparam int DEPTH = 100;
   localparam int KEY_W = 16;
   localparam int PAY_W = 64;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clear = 1'b0;
   logic             mode = 1'b0;
   logic             in_valid = 1'b0;
   logic [KEY_W-1:0] in_key = '0;
   logic [PAY_W-1:0] in_payload = '0;
   logic             out_valid;
   logic [PAY_W-1:0] out_payload;
   logic             dup_err;
   logic             full;
   logic [CNT_W-1:0] count;

   always #5 clk = ~clk;

   keyed_shift_sorter #(.DEPTH(DEPTH), .KEY_W(KEY_W), .PAY_W(PAY_W)) u_keyed_shift_sorter (
      .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode), .in_valid(in_valid),
      .in_key(in_key), .in_payload(in_payload), .out_valid(out_valid),
      .out_payload(out_payload), .dup_err(dup_err), .full(full), .count(count)
   );

   typedef struct {
      int          key;
      logic [63:0] pay;
   } rec_t;

   rec_t        mq[$];
   int          m_addr;
   logic        m_ov;
   logic [63:0] m_op;
   logic        m_dup;
   int          popped[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   function automatic logic [63:0] mk_pay(input int k, input int tag);
      return {k[15:0], 16'hA5C3, tag[31:0]};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // behavioural reference: one step per rising edge
   task automatic model_step();
      if (clear) begin
         mq.delete();
         m_ov = 0; m_op = '0; m_dup = 0;
      end else if (mode == 1'b0) begin
         m_ov = 0; m_op = '0; m_dup = 0;
         if (in_valid) begin
            int pos;
            pos = mq.size();
            for (int j = 0; j < mq.size(); j++) begin
               if (mq[j].key == int'(in_key)) m_dup = 1;
            end
            for (int j = mq.size() - 1; j >= 0; j--) begin
               if (mq[j].key > int'(in_key)) pos = j;
            end
            if (!m_dup && mq.size() < DEPTH) begin
               rec_t r;
               r.key = int'(in_key);
               r.pay = in_payload;
               mq.insert(pos, r);
            end
         end
      end else begin
         m_dup = 0;
         if (mq.size() > 0 && mq[0].key == m_addr) begin
            m_ov = 1;
            m_op = mq[0].pay;
            void'(mq.pop_front());
         end else begin
            m_ov = 0;
            m_op = '0;
         end
      end
      m_addr = mode ? ((m_addr + 1) & 16'hFFFF) : 0;
   endtask

   task automatic compare();
      chk("R6 out_valid", 64'(out_valid), 64'(m_ov));
      chk("R6 out_payload", out_payload, m_op);
      chk("R4 dup_err", 64'(dup_err), 64'(m_dup));
      chk("R3 count", 64'(count), 64'(mq.size()));
      chk("R5 full", 64'(full), 64'(mq.size() == DEPTH));
      if (out_valid) popped.push_back(int'(out_payload[63:48]));
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic put(input int k, input int tag);
      mode = 1'b0; clear = 1'b0; in_valid = 1'b1;
      in_key = k[15:0]; in_payload = mk_pay(k, tag);
      tick();
      in_valid = 1'b0;
   endtask

   task automatic read_for(input int n);
      mode = 1'b1; in_valid = 1'b0; clear = 1'b0;
      for (int j = 0; j < n; j++) tick();
   endtask

   task automatic check_order(input string tag, input int exp[$]);
      chk({tag, " popped size"}, 64'(popped.size()), 64'(exp.size()));
      for (int j = 0; j < exp.size() && j < popped.size(); j++) begin
         chk({tag, " key order"}, 64'(popped[j]), 64'(exp[j]));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int exp[$];
      int n;
      m_addr = 0; m_ov = 0; m_op = '0; m_dup = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      chk("R10 count", 64'(count), 0);
      chk("R10 full", 64'(full), 0);
      chk("R10 out_valid", 64'(out_valid), 0);
      chk("R10 out_payload", out_payload, 0);
      chk("R10 dup_err", 64'(dup_err), 0);

      // R1, R4: back-to-back loads in scrambled order with one duplicate
      put(500, 1); put(20, 2); put(300, 3); put(7, 4);
      put(300, 5);
      chk("R4 duplicate strobe", 64'(dup_err), 1);
      put(1000, 6);
      chk("R4 strobe one cycle", 64'(dup_err), 0);
      put(0, 7);
      chk("R1 count after loads", 64'(count), 6);
      popped.delete();
      read_for(1010);
      exp = '{0, 7, 20, 300, 500, 1000};
      check_order("R1", exp);
      for (int j = 1; j < popped.size(); j++)
         chk("R2 ascending", 64'(popped[j] > popped[j-1]), 1);

      // R8: insert attempts in readout mode are ignored
      mode = 1'b1; in_valid = 1'b1; in_key = 16'd5; in_payload = mk_pay(5, 9);
      tick(); tick();
      in_valid = 1'b0;
      chk("R8 count unchanged", 64'(count), 0);

      // R7: counter restarts at zero on each readout entry
      put(50, 10); put(2000, 11);
      read_for(60);
      put(10, 12);
      mode = 1'b1;
      n = 0;
      do begin
         tick();
         n++;
      end while (!out_valid && n < 100);
      chk("R7 key 10 on readout clock 11", 64'(n), 11);
      read_for(2000);
      chk("R7 all drained", 64'(count), 0);

      // R9: clear overrides an insert and a readout match
      put(4, 13); put(9, 14); put(2, 15);
      clear = 1'b1; in_valid = 1'b1; in_key = 16'd30; mode = 1'b0;
      tick();
      clear = 1'b0; in_valid = 1'b0;
      chk("R9 count cleared", 64'(count), 0);
      put(2, 16);
      read_for(2);
      clear = 1'b1;
      tick();
      clear = 1'b0;
      chk("R9 match suppressed", 64'(out_valid), 0);
      chk("R9 empty after clear", 64'(count), 0);
      mode = 1'b0;
      tick();

      // R5: fill every slot, including the extreme keys
      exp.delete();
      for (int i = 0; i < DEPTH; i++) begin
         int p, k;
         p = (i * 37) % DEPTH;
         k = (p == 0) ? 0 : (p == DEPTH - 1) ? 65535 : p * 655 + 3;
         put(k, 100 + i);
      end
      chk("R5 full raised", 64'(full), 1);
      put(1, 300);
      chk("R5 new key dropped when full", 64'(count), DEPTH);
      chk("R5 no dup strobe", 64'(dup_err), 0);
      put(655 + 3, 301);
      chk("R4 dup while full", 64'(dup_err), 1);
      for (int p = 0; p < DEPTH; p++)
         exp.push_back((p == 0) ? 0 : (p == DEPTH - 1) ? 65535 : p * 655 + 3);
      popped.delete();
      read_for(65540);
      check_order("R2", exp);
      chk("R5 full cleared after drain", 64'(full), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule